// File: doc/BRIEF.md
# Double-Buffered DAC Update Controller

This block is the register side of a six-channel, 12-bit analog output card. A host writes each channel's code one byte at a time through a byte-wide port. The bytes go into a preload register for that channel. Output registers drive the converters, and a small mode engine decides when preload contents are copied into them. Reads from the port carry no data. Instead, reading certain offsets acts as a command: update every channel at once, switch between simultaneous and automatic update, clamp the outputs, or release the clamp.

In simultaneous mode, writes are held back until an update command. All channels then change on the same clock. In automatic mode, a channel's output register loads as soon as its high byte arrives.

From reset, every output is clamped to a safe band around mid-scale. The clamp stays until the host issues the release command. This gives software time to fill the preload registers, which are not cleared by reset. An active-low trigger pin, when armed by a command, also updates all channels for as long as it stays low. The converter outputs are registered.

Top module: `dac_update_ctrl`

## Requirements
- R1: Reset (synchronous, active high) puts the block in simultaneous mode with the clamp on and the trigger disarmed. Every output register and every `dac_out` lane returns to mid-scale 2048. Preload registers keep their contents through reset.
- R2: For channel c, a write to offset 2c loads preload bits 7:0 from `bus_wdata[7:0]`. A write to offset 2c+1 loads preload bits 11:8 from `bus_wdata[3:0]`, and `bus_wdata[7:4]` is ignored.
- R3: A read of offset 8 copies every channel's preload into its output register on the same clock, in either mode. In simultaneous mode, no output register changes without an update command.
- R4: A read of offset 0xA copies every preload into the output registers and leaves the block in automatic mode.
- R5: A read of offset 2 selects automatic mode and leaves every output register unchanged.
- R6: In automatic mode, a high-byte write to a channel loads that channel's output register with the new 12-bit code on the same clock.
- R7: A low-byte write alone never changes any output register, in either mode.
- R8: A read of offset 0xE turns the clamp on, and a read of offset 0xF turns it off. While the clamp is on, each lane shows its output register limited to the range [1434, 2662], which is 2048 ± floor(15% of 4096). The output registers keep their real codes, so a release shows them unchanged.
- R9: A read of offset 5 arms the trigger, and a read of offset 6 disarms it. `trig_n` passes through two synchronizing flops. While the trigger is armed, each cycle in which the synchronized level is low updates all channels. While it is disarmed, the pin has no effect.
- R10: Writes to offsets 12 to 15 and reads of offsets not named above change no output.
- R11: `dac_out` lane c (bits 12c+11:12c) shows the output register, clamped when the clamp is on, one clock after the output register loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset of the current access |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per command |
| bus_wdata | input | 8 | Write data byte |
| trig_n | input | 1 | Asynchronous active-low update trigger |
| dac_out | output | 72 | Six 12-bit converter codes, channel 0 in the low bits |

## Verification
The assertions assume that the host issues at most one access per cycle, so `bus_rd` and `bus_wr` are never high together, and that `bus_addr` is stable for the cycle of its strobe. They also assume that no update reaches a channel before both of its preload bytes have been written, so no undefined code is ever copied out. The stimulus drives one strobe per cycle from a task with idle cycles between accesses. It fills all six preload registers before the first update command. The trigger pin is only lowered after every channel holds a known code.

// File: rtl/dac_pkg.sv
package dac_pkg;

  typedef enum logic {
    MODE_SIM  = 1'b0,
    MODE_AUTO = 1'b1
  } upd_mode_e;

  // read-command offsets
  localparam int unsigned OFS_GO_AUTO   = 2;
  localparam int unsigned OFS_TRIG_ARM  = 5;
  localparam int unsigned OFS_TRIG_DIS  = 6;
  localparam int unsigned OFS_UPD_ALL   = 8;
  localparam int unsigned OFS_UPD_AUTO  = 10;
  localparam int unsigned OFS_CLAMP_ON  = 14;
  localparam int unsigned OFS_CLAMP_OFF = 15;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/dac_sync2.sv
module dac_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
  import dac_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              trig_low,
  output logic              auto_mode,
  output logic              clamp_on,
  output logic              trig_armed,
  output logic              update_all
);
  upd_mode_e mode_q;
  logic rd_go_auto, rd_arm, rd_dis, rd_upd, rd_upd_auto, rd_c_on, rd_c_off;

  always_comb begin
    rd_go_auto  = bus_rd && (bus_addr == ADDR_W'(OFS_GO_AUTO));
    rd_arm      = bus_rd && (bus_addr == ADDR_W'(OFS_TRIG_ARM));
    rd_dis      = bus_rd && (bus_addr == ADDR_W'(OFS_TRIG_DIS));
    rd_upd      = bus_rd && (bus_addr == ADDR_W'(OFS_UPD_ALL));
    rd_upd_auto = bus_rd && (bus_addr == ADDR_W'(OFS_UPD_AUTO));
    rd_c_on     = bus_rd && (bus_addr == ADDR_W'(OFS_CLAMP_ON));
    rd_c_off    = bus_rd && (bus_addr == ADDR_W'(OFS_CLAMP_OFF));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MODE_SIM;
      clamp_on   <= 1'b1;
      trig_armed <= 1'b0;
    end else begin
      if (rd_go_auto || rd_upd_auto) mode_q <= MODE_AUTO;
      if (rd_c_on)       clamp_on <= 1'b1;
      else if (rd_c_off) clamp_on <= 1'b0;
      if (rd_arm)        trig_armed <= 1'b1;
      else if (rd_dis)   trig_armed <= 1'b0;
    end
  end

  always_comb begin
    auto_mode  = (mode_q == MODE_AUTO);
    update_all = rd_upd || rd_upd_auto || (trig_armed && trig_low);
  end
endmodule

// File: rtl/dac_channel.sv
module dac_channel
  import dac_pkg::*;
#(
  parameter int CODE_W    = 12,
  parameter int LIMIT_PCT = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              update_all,
  input  logic              auto_mode,
  input  logic              clamp_on,
  output logic [CODE_W-1:0] code_q,
  output logic [CODE_W-1:0] dac_q
);
  localparam int LO_W  = BYTE_W;
  localparam int HI_W  = CODE_W - LO_W;
  localparam int SPAN  = 1 << CODE_W;
  localparam int MID   = SPAN / 2;
  localparam int LIM   = (SPAN * LIMIT_PCT) / 100;
  localparam logic [CODE_W-1:0] MID_C   = CODE_W'(MID);
  localparam logic [CODE_W-1:0] FLOOR_C = CODE_W'(MID - LIM);
  localparam logic [CODE_W-1:0] CEIL_C  = CODE_W'(MID + LIM);

  logic [LO_W-1:0]   pre_lo, nxt_lo;
  logic [HI_W-1:0]   pre_hi, nxt_hi;
  logic              load;
  logic [CODE_W-1:0] shown;

  always_comb begin
    nxt_lo = lo_we ? wdata : pre_lo;
    nxt_hi = hi_we ? wdata[HI_W-1:0] : pre_hi;
    load   = update_all || (auto_mode && hi_we);
  end

  // preload: no reset, contents undefined until written
  always_ff @(posedge clk) begin
    pre_lo <= nxt_lo;
    pre_hi <= nxt_hi;
  end

  always_ff @(posedge clk) begin
    if (rst)       code_q <= MID_C;
    else if (load) code_q <= {nxt_hi, nxt_lo};
  end

  always_comb begin
    shown = code_q;
    if (clamp_on) begin
      if (code_q < FLOOR_C)     shown = FLOOR_C;
      else if (code_q > CEIL_C) shown = CEIL_C;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dac_q <= MID_C;
    else     dac_q <= shown;
  end
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
  import dac_pkg::*;
#(
  parameter int NCH       = 6,
  parameter int CODE_W    = 12,
  parameter int ADDR_W    = 4,
  parameter int LIMIT_PCT = 15
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [BYTE_W-1:0]     bus_wdata,
  input  logic                  trig_n,
  output logic [NCH*CODE_W-1:0] dac_out
);
  localparam int OUT_W = NCH * CODE_W;

  logic             trig_s;
  logic             auto_mode, clamp_on, trig_armed, update_all;
  logic [OUT_W-1:0] code_flat;

  dac_sync2 #(.RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(trig_n), .q(trig_s)
  );

  dac_cmd_ctrl #(.ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .trig_low(~trig_s), .auto_mode(auto_mode), .clamp_on(clamp_on),
    .trig_armed(trig_armed), .update_all(update_all)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic lo_we, hi_we;
    always_comb begin
      lo_we = bus_wr && (bus_addr == ADDR_W'(2 * c));
      hi_we = bus_wr && (bus_addr == ADDR_W'(2 * c + 1));
    end
    dac_channel #(.CODE_W(CODE_W), .LIMIT_PCT(LIMIT_PCT)) u_ch (
      .clk(clk), .rst(rst), .lo_we(lo_we), .hi_we(hi_we),
      .wdata(bus_wdata), .update_all(update_all), .auto_mode(auto_mode),
      .clamp_on(clamp_on),
      .code_q(code_flat[c*CODE_W +: CODE_W]),
      .dac_q(dac_out[c*CODE_W +: CODE_W])
    );
  end
endmodule

// File: rtl/dac_update_ctrl_chk.sv
module dac_update_ctrl_chk #(
  parameter int NCH       = 6,
  parameter int CODE_W    = 12,
  parameter int ADDR_W    = 4,
  parameter int LIMIT_PCT = 15
) (
  input logic                  clk,
  input logic                  rst,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic                  auto_mode,
  input logic                  clamp_on,
  input logic                  trig_armed,
  input logic [NCH*CODE_W-1:0] code_flat,
  input logic [NCH*CODE_W-1:0] dac_out
);
  localparam int SPAN = 1 << CODE_W;
  localparam int LIM  = (SPAN * LIMIT_PCT) / 100;
  localparam logic [CODE_W-1:0] LO_B = CODE_W'(SPAN / 2 - LIM);
  localparam logic [CODE_W-1:0] HI_B = CODE_W'(SPAN / 2 + LIM);

  logic rd_upd_any;
  assign rd_upd_any = bus_rd && (bus_addr == ADDR_W'(8) || bus_addr == ADDR_W'(10));

  AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!auto_mode && clamp_on && !trig_armed)); // R1

  AST_SIM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!auto_mode && !rd_upd_any && !trig_armed) |=> $stable(code_flat)); // R3

  AST_UPD_AUTO_MODE: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(10)) |=> auto_mode); // R4

  AST_GO_AUTO_MODE: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(2)) |=> auto_mode); // R5

  AST_LOW_BYTE_INERT: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_addr[0] && !trig_armed) |=> $stable(code_flat)); // R7

  AST_CLAMP_SET: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(14)) |=> clamp_on); // R8

  AST_TRIG_DISARM: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(6)) |=> !trig_armed); // R9

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    AST_CLAMP_BAND: assert property (@(posedge clk) disable iff (rst)
      clamp_on |=> (dac_out[c*CODE_W +: CODE_W] >= LO_B &&
                    dac_out[c*CODE_W +: CODE_W] <= HI_B)); // R8
  end
endmodule

bind dac_update_ctrl dac_update_ctrl_chk #(
  .NCH(NCH), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .LIMIT_PCT(LIMIT_PCT)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .auto_mode(auto_mode), .clamp_on(clamp_on), .trig_armed(trig_armed),
  .code_flat(code_flat), .dac_out(dac_out)
);

// File: tb/sim_dac_update_ctrl.sv
`timescale 1ns/1ps
module sim_dac_update_ctrl;
  localparam int NCH = 6;
  localparam int CW  = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic          trig_n = 1'b1;
  logic [NCH*CW-1:0] dac_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  int m_pre [NCH];
  int m_out [NCH];
  int m_dout[NCH];
  int m_auto = 0, m_lim = 1, m_ten = 0, m_s1 = 1, m_s2 = 1;

  always #2.5 clk = ~clk;

  dac_update_ctrl u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .trig_n(trig_n), .dac_out(dac_out)
  );

  function automatic int clampv(int v);
    if (v < 1434) return 1434;
    if (v > 2662) return 2662;
    return v;
  endfunction

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_pre[c] = 0; m_out[c] = 2048; m_dout[c] = 2048;
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin m_out[c] = 2048; m_dout[c] = 2048; end
      m_auto = 0; m_lim = 1; m_ten = 0; m_s1 = 1; m_s2 = 1;
    end else begin
      int a;
      bit upd;
      a = int'(bus_addr);
      for (int c = 0; c < NCH; c++) m_dout[c] = m_lim ? clampv(m_out[c]) : m_out[c];
      upd = (bus_rd && (a == 8 || a == 10)) || (m_ten == 1 && m_s2 == 0);
      for (int c = 0; c < NCH; c++) begin
        int np;
        np = m_pre[c];
        if (bus_wr && a == 2*c)   np = (np & 'hF00) | int'(bus_wdata);
        if (bus_wr && a == 2*c+1) np = (np & 'h0FF) | (int'(bus_wdata[3:0]) << 8);
        if (upd || (m_auto == 1 && bus_wr && a == 2*c+1)) m_out[c] = np;
        m_pre[c] = np;
      end
      if (bus_rd && (a == 2 || a == 10)) m_auto = 1;
      if (bus_rd && a == 14) m_lim = 1;
      if (bus_rd && a == 15) m_lim = 0;
      if (bus_rd && a == 5) m_ten = 1;
      if (bus_rd && a == 6) m_ten = 0;
      m_s2 = m_s1;
      m_s1 = int'(trig_n);
    end
  end

  // per-clock comparison against the reference (R11 timing)
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit bad;
      bad = 1'b0;
      n_chk++;
      for (int c = 0; c < NCH; c++) begin
        if (int'(dac_out[c*CW +: CW]) != m_dout[c] || $isunknown(dac_out[c*CW +: CW])) begin
          if (!bad)
            $display("FAIL %s/R11 model lane %0d actual %0d expected %0d",
                     cur_req, c, dac_out[c*CW +: CW], m_dout[c]);
          bad = 1'b1;
        end
      end
      if (bad) n_fail++;
    end
  end

  task automatic chk(string req, int ch, int exp);
    int act;
    act = int'(dac_out[ch*CW +: CW]);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s lane %0d actual %0d expected %0d", req, ch, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 8'(d);
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(int a);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 4'(a);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put(int ch, int v);
    wr(2*ch, v & 'hFF);
    wr(2*ch+1, ((v >> 8) & 'hF) | 'hA0);   // upper nibble must be ignored (R2)
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(1);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    cur_req = "R1";
    for (int c = 0; c < NCH; c++) chk("R1 reset mid-scale", c, 2048);

    cur_req = "R3";
    put(0, 'h123); put(1, 'hA00); put(2, 'hFFF);
    put(3, 'h000); put(4, 'h800); put(5, 'h5A5);
    rd(15);                                  // release clamp
    idle(2);
    chk("R3 held before update", 0, 2048);
    chk("R3 held before update", 2, 2048);
    rd(8);
    idle(2);
    chk("R3 update all", 0, 'h123);
    chk("R2 high nibble only", 1, 'hA00);
    chk("R3 update all", 2, 4095);
    chk("R3 update all", 3, 0);
    chk("R3 update all", 5, 'h5A5);

    cur_req = "R8";
    rd(14);
    idle(2);
    chk("R8 clamp low", 0, 1434);
    chk("R8 clamp high", 2, 2662);
    chk("R8 clamp low", 3, 1434);
    chk("R8 inside band", 5, 'h5A5);
    rd(15);
    idle(2);
    chk("R8 release keeps code", 2, 4095);
    chk("R8 release keeps code", 3, 0);

    cur_req = "R5";
    put(1, 'h300);
    rd(2);
    idle(2);
    chk("R5 no update on mode switch", 1, 'hA00);

    cur_req = "R6";
    wr(3, 'h03);
    idle(2);
    chk("R6 auto high-byte load", 1, 'h300);

    cur_req = "R7";
    wr(0, 'h99);
    idle(2);
    chk("R7 low byte alone", 0, 'h123);
    wr(1, 'h01);
    idle(2);
    chk("R6 auto high-byte load", 0, 'h199);

    cur_req = "R10";
    wr(12, 'h55); wr(13, 'h66); wr(15, 'h77);
    rd(0); rd(1); rd(3); rd(4); rd(7); rd(9); rd(11); rd(12); rd(13);
    idle(2);
    chk("R10 no effect", 0, 'h199);
    chk("R10 no effect", 4, 'h800);
    wr(8, 'h34);
    idle(2);
    chk("R10 clamp still off", 4, 'h800);

    cur_req = "R1";
    do_reset();
    chk("R1 reset output", 2, 2048);

    cur_req = "R4";
    rd(15);
    rd(10);
    idle(2);
    chk("R4 preload kept over reset", 2, 4095);
    chk("R4 preload kept over reset", 0, 'h199);
    put(2, 'h0F0);
    idle(2);
    chk("R4 now automatic", 2, 'h0F0);

    cur_req = "R9";
    do_reset();
    rd(15);
    put(3, 'h321);
    @(negedge clk); trig_n = 1'b0;
    idle(6);
    chk("R9 disarmed trigger ignored", 3, 2048);
    trig_n = 1'b1;
    idle(3);
    rd(5);
    @(negedge clk); trig_n = 1'b0;
    idle(5);
    chk("R9 armed trigger updates", 3, 'h321);
    trig_n = 1'b1;
    idle(3);
    rd(6);
    put(3, 'h111);
    @(negedge clk); trig_n = 1'b0;
    idle(6);
    chk("R9 disarm stops trigger", 3, 'h321);
    trig_n = 1'b1;
    idle(3);
    rd(8);
    idle(2);
    chk("R3 update after trigger tests", 3, 'h111);

    finish_run();
  end
endmodule